// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one 16-bit channel register that works beside a free-running 16-bit up-counter. It has two roles, and a configuration bit chooses between them. In compare role the register holds a target value. Each time the counter arrives at that value, the channel raises a single-cycle interrupt request. When the counter serves as an interval timer, the register holds the interval. In capture role the register takes a snapshot of the counter when a qualified transition appears on one of two asynchronous input pins.

Each pin is resynchronized and passed through an edge detector. A source-select bit chooses which pin can trigger a capture. The two pins decode their 2-bit edge-select codes differently. On the first pin the capture edge is the opposite of the edge that the code marks as valid, and the both-edges code disables capture on that pin. On the second pin the coded edge is used as it stands. Software loads the register through a plain write port. A write takes precedence over a capture that lands in the same cycle.

Top module: `tmr_capcmp_chan`

## Requirements
- R1: While `rst` is high at a clock edge, `chan_val` becomes 0000H and `match_irq` becomes 0.
- R2: `wr_en` high at a clock edge loads `wr_data` into `chan_val`, in either role.
- R3: With `mode_cap`=0, `match_irq` is high for exactly one cycle, one edge after the counter takes a new value equal to `chan_val`. A counter that holds an equal value yields no further pulse.
- R4: A compare value of 0000H does not fire while the counter sits at its post-reset count of 0000H. It fires when the counter wraps from FFFFH to 0000H.
- R5: First pin, `esel_a`=00: capture on a rising transition only. `esel_a`=01: capture on a falling transition only.
- R6: First pin, `esel_a`=11 (both edges valid) or 10 (reserved): no capture on any transition.
- R7: Second pin: `esel_b`=00 captures on falling, 01 on rising, 11 on both, and 10 on neither.
- R8: `src_sel`=0 makes the first pin the only capture source and `src_sel`=1 the second pin. The unselected pin has no effect on `chan_val`.
- R9: A pin change first sampled at clock edge E1 stores the `count` value present at edge E4 (two synchronizer flops, one edge register, then the load).
- R10: When a write and a capture fall on the same edge, `chan_val` takes `wr_data`, and the capture is lost.
- R11: With `mode_cap`=1, `match_irq` stays 0. With `mode_cap`=0, pin transitions leave `chan_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Value to write into the channel register |
| mode_cap | input | 1 | Role: 0 compare, 1 capture |
| src_sel | input | 1 | Capture source: 0 first pin, 1 second pin |
| esel_a | input | 2 | Edge-select code of the first pin |
| esel_b | input | 2 | Edge-select code of the second pin |
| pin_a | input | 1 | First asynchronous input pin |
| pin_b | input | 1 | Second asynchronous input pin |
| count | input | 16 | Current counter value |
| chan_val | output | 16 | Channel register contents |
| match_irq | output | 1 | One-cycle compare-match interrupt request |

## Verification
A register write and a pin-triggered capture can land on the same clock edge. The bench provokes this by changing a pin and then raising `wr_en` exactly three edges later, so the write meets the load edge of the capture. It judges the result by requiring the written value in `chan_val` on that cycle and on the cycles that follow. Separately, compare matches and captures are excluded from each other by role. The bench drives the counter onto the register value while in capture role, and toggles pins while in compare role.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // 2-bit edge-select codes; meaning depends on the pin (see tcc_trig_dec)
  typedef enum logic [1:0] {
    ESEL_C0   = 2'b00,
    ESEL_C1   = 2'b01,
    ESEL_RSVD = 2'b10,
    ESEL_BOTH = 2'b11
  } esel_t;

  localparam int unsigned NUM_PINS = 2;

endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              synced;

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      hist_q <= synced;
      rise   <= synced & ~hist_q;
      fall   <= ~synced & hist_q;
    end
  end

endmodule

// File: rtl/tcc_trig_dec.sv
module tcc_trig_dec
  import tcc_pkg::*;
#(
  parameter int unsigned        NPINS    = NUM_PINS,
  parameter logic [NPINS-1:0]   OPP_MASK = 2'b01
) (
  input  logic [NPINS-1:0]       rise,
  input  logic [NPINS-1:0]       fall,
  input  logic [NPINS-1:0][1:0]  esel,
  output logic [NPINS-1:0]       trig
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (OPP_MASK[i]) begin : g_opp
      // capture edge is opposite of the coded valid edge; both-edge code disables
      always_comb begin
        unique case (esel_t'(esel[i]))
          ESEL_C0: trig[i] = rise[i];
          ESEL_C1: trig[i] = fall[i];
          default: trig[i] = 1'b0;
        endcase
      end
    end else begin : g_dir
      always_comb begin
        unique case (esel_t'(esel[i]))
          ESEL_C0:   trig[i] = fall[i];
          ESEL_C1:   trig[i] = rise[i];
          ESEL_BOTH: trig[i] = rise[i] | fall[i];
          default:   trig[i] = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/tcc_cmp.sv
module tcc_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] count,
  input  logic [W-1:0] ref_val,
  output logic         irq
);

  logic [W-1:0] prev_q;
  logic         fresh;

  // match only counts when the counter has moved to a new value
  assign fresh = (count != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= count;
      irq    <= enable & fresh & (count == ref_val);
    end
  end

endmodule

// File: rtl/tmr_capcmp_chan.sv
module tmr_capcmp_chan
  import tcc_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         mode_cap,
  input  logic         src_sel,
  input  logic [1:0]   esel_a,
  input  logic [1:0]   esel_b,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic [W-1:0] count,
  output logic [W-1:0] chan_val,
  output logic         match_irq
);

  localparam int unsigned NPINS = NUM_PINS;

  logic [NPINS-1:0]      pins;
  logic [NPINS-1:0]      rise;
  logic [NPINS-1:0]      fall;
  logic [NPINS-1:0][1:0] esel;
  logic [NPINS-1:0]      trig;
  logic                  cap_fire;
  logic [W-1:0]          val_q;

  assign pins = {pin_b, pin_a};
  assign esel = {esel_b, esel_a};

  for (genvar i = 0; i < NPINS; i++) begin : g_in
    tcc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .pin  (pins[i]),
      .rise (rise[i]),
      .fall (fall[i])
    );
  end

  tcc_trig_dec #(.NPINS(NPINS), .OPP_MASK(2'b01)) u_dec (
    .rise (rise),
    .fall (fall),
    .esel (esel),
    .trig (trig)
  );

  assign cap_fire = mode_cap & trig[src_sel];

  // write has priority over a coincident capture
  always_ff @(posedge clk) begin
    if (rst)           val_q <= '0;
    else if (wr_en)    val_q <= wr_data;
    else if (cap_fire) val_q <= count;
  end

  tcc_cmp #(.W(W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .enable  (~mode_cap),
    .count   (count),
    .ref_val (val_q),
    .irq     (match_irq)
  );

  assign chan_val = val_q;

endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         mode_cap,
  input logic [W-1:0] count,
  input logic [W-1:0] chan_val,
  input logic         match_irq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (chan_val == '0) && !match_irq);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) |-> chan_val == $past(wr_data));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    match_irq |=> !match_irq);

  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> ($past(count) == $past(chan_val)) && !$past(mode_cap));

  // R11
  cap_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode_cap) && !$past(rst) |-> !match_irq);

  // R11
  cmp_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_cap) && !$past(wr_en) && !$past(rst) |-> $stable(chan_val));

endmodule

bind tmr_capcmp_chan tcc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .mode_cap  (mode_cap),
  .count     (count),
  .chan_val  (chan_val),
  .match_irq (match_irq)
);

// File: tb/tmr_capcmp_chan_bench.sv
`timescale 1ns/1ps
module tmr_capcmp_chan_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        mode_cap;
  logic        src_sel;
  logic [1:0]  esel_a;
  logic [1:0]  esel_b;
  logic        pin_a;
  logic        pin_b;
  logic [15:0] count;
  logic [15:0] chan_val;
  logic        match_irq;

  always #2.5 clk = ~clk;

  tmr_capcmp_chan u_tmr_capcmp_chan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mode_cap(mode_cap), .src_sel(src_sel), .esel_a(esel_a), .esel_b(esel_b),
    .pin_a(pin_a), .pin_b(pin_b), .count(count),
    .chan_val(chan_val), .match_irq(match_irq)
  );

  typedef struct {
    string       req;
    int          kind;   // 0: chan_val, 1: match_irq
    logic [15:0] exp;
  } item_t;

  item_t       exp_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic [15:0] mdl    = 16'h0000;
  logic [15:0] seed   = 16'h1000;

  // monitor: pops expected items and compares against live outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        item_t it;
        logic [15:0] act;
        it  = exp_q.pop_front();
        act = (it.kind == 0) ? chan_val : {15'd0, match_irq};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, int kind, logic [15:0] e);
    item_t it;
    it.req = req; it.kind = kind; it.exp = e;
    exp_q.push_back(it);
    #0.1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_pin(int which, logic v);
    if (which == 0) pin_a = v; else pin_b = v;
  endtask

  // drive a pin transition with a unique count held; expect capture or not
  task automatic probe(string req, int which, logic v, bit cap);
    logic [15:0] cv;
    cv   = seed;
    seed = seed + 16'h0111;
    count = cv;
    set_pin(which, v);
    run(6);
    count = ~cv;
    tick();
    if (cap) mdl = cv;
    push(req, 0, mdl);
  endtask

  task automatic step_cnt(string req, logic [15:0] v, logic e);
    count = v;
    tick();
    push(req, 1, {15'd0, e});
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_data = 0; mode_cap = 0; src_sel = 0;
    esel_a = 2'b00; esel_b = 2'b00; pin_a = 0; pin_b = 0; count = 0;
    run(3);
    rst = 0;
    // R1 reset state
    push("R1", 0, 16'h0000);
    push("R1", 1, 16'h0000);

    // R4 zero compare: no fire while held at 0, fires on wrap
    run(3);
    push("R4", 1, 16'h0000);
    step_cnt("R4", 16'hFFFE, 1'b0);
    step_cnt("R4", 16'hFFFF, 1'b0);
    step_cnt("R4", 16'h0000, 1'b1);
    tick();
    push("R4", 1, 16'h0000);

    // R2 write
    wr_en = 1; wr_data = 16'h0123;
    tick();
    wr_en = 0;
    mdl = 16'h0123;
    push("R2", 0, mdl);

    // R3 compare pulse
    step_cnt("R3", 16'h0121, 1'b0);
    step_cnt("R3", 16'h0122, 1'b0);
    step_cnt("R3", 16'h0123, 1'b1);
    step_cnt("R3", 16'h0123, 1'b0);
    step_cnt("R3", 16'h0124, 1'b0);

    // R11 no interrupt in capture role
    mode_cap = 1;
    step_cnt("R11", 16'h0200, 1'b0);
    step_cnt("R11", 16'h0123, 1'b0);

    // R5 first pin, opposite-edge decode
    src_sel = 0; esel_a = 2'b00;
    probe("R5", 0, 1'b1, 1'b1);
    probe("R5", 0, 1'b0, 1'b0);
    esel_a = 2'b01;
    probe("R5", 0, 1'b1, 1'b0);
    probe("R5", 0, 1'b0, 1'b1);
    // R6 both-edge and reserved codes disable
    esel_a = 2'b11;
    probe("R6", 0, 1'b1, 1'b0);
    probe("R6", 0, 1'b0, 1'b0);
    esel_a = 2'b10;
    probe("R6", 0, 1'b1, 1'b0);
    probe("R6", 0, 1'b0, 1'b0);

    // R7 second pin, direct decode
    src_sel = 1;
    esel_b = 2'b00;
    probe("R7", 1, 1'b1, 1'b0);
    probe("R7", 1, 1'b0, 1'b1);
    esel_b = 2'b01;
    probe("R7", 1, 1'b1, 1'b1);
    probe("R7", 1, 1'b0, 1'b0);
    esel_b = 2'b11;
    probe("R7", 1, 1'b1, 1'b1);
    probe("R7", 1, 1'b0, 1'b1);
    esel_b = 2'b10;
    probe("R7", 1, 1'b1, 1'b0);
    probe("R7", 1, 1'b0, 1'b0);

    // R8 unselected pin ignored
    esel_a = 2'b00; esel_b = 2'b11;
    src_sel = 1;
    probe("R8", 0, 1'b1, 1'b0);
    probe("R8", 0, 1'b0, 1'b0);
    src_sel = 0;
    probe("R8", 1, 1'b1, 1'b0);
    probe("R8", 1, 1'b0, 1'b0);

    // R9 latency: count changes every cycle, value at E4 is stored
    src_sel = 0; esel_a = 2'b00;
    count = 16'h3100; pin_a = 1;
    tick(); count = 16'h3101;
    tick(); count = 16'h3102;
    tick(); count = 16'h3103;
    tick(); count = 16'h3104;
    mdl = 16'h3103;
    push("R9", 0, mdl);
    run(4);
    push("R9", 0, mdl);

    // R10 write coincides with capture edge
    count = 16'h4444; pin_a = 0; run(6);
    esel_a = 2'b01;
    count = 16'h5555; pin_a = 1; run(6);
    pin_a = 0;
    tick(); tick(); tick();
    wr_en = 1; wr_data = 16'hBEEF;
    tick();
    wr_en = 0;
    mdl = 16'hBEEF;
    push("R10", 0, mdl);
    run(4);
    push("R10", 0, mdl);

    // R11 compare role ignores pin transitions
    mode_cap = 0; esel_a = 2'b00;
    probe("R11", 0, 1'b1, 1'b0);
    probe("R11", 0, 1'b0, 1'b0);

    // R1 reset clears again
    rst = 1;
    tick();
    rst = 0;
    push("R1", 0, 16'h0000);
    push("R1", 1, 16'h0000);

    wait (exp_q.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule